// File: doc/BRIEF.md
# Branch Trace Ring Buffer

This block keeps a short history of control-flow changes. Each qualified event arrives as one strobe carrying the address the flow left (the source) and the address it went to (the destination). The event may be a taken jump, a conditional branch, a loop, a call, or an asynchronous redirect such as an interrupt, trap or fault. The block does not tell these kinds apart. Events are stored in a circular buffer of `DEPTH` entries, and each entry is a source/destination pair. A pointer names the entry that holds the newest event. Once the buffer is full, each new event overwrites the oldest entry.

Software reads the history through a register-style port. The register address is split into two parts. The upper two bits pick a bank: source addresses, destination addresses, or the pointer register. The low bits give the entry index, so entry 0 to entry `DEPTH-1` sit at consecutive addresses. Software may also load the pointer. A global enable stops recording without disturbing the stored history.

Top module: `branch_trace_ring`

## Requirements
- R1: After a synchronous active-low reset, the pointer is `DEPTH-1` and every source and destination entry reads as zero.
- R2: When `rec_enable` is high and `evt_valid` is high (and no pointer load occurs), the pointer first advances by one modulo `DEPTH`. The event's source and destination are then written into the entry the new pointer names. The first event after reset therefore lands in entry 0.
- R3: When the pointer is at `DEPTH-1`, the next recorded event wraps the pointer to 0 and overwrites the oldest entry. Every other entry keeps its value.
- R4: While `rec_enable` is low, event strobes are ignored. The pointer and all entries hold their values.
- R5: The read address is `{bank, index}`, with the bank in the two most significant bits. Bank 0 returns source field `index`, bank 1 returns destination field `index`, bank 2 returns the pointer register, and bank 3 returns zero. `rd_data` shows the result one clock after `rd_addr` is presented.
- R6: A read of the pointer register returns the pointer in its low `log2(DEPTH)` bits, and all higher bits read as zero.
- R7: When `tos_wr_en` is high, the pointer loads `tos_wr_data[log2(DEPTH)-1:0]` and the higher bits of `tos_wr_data` are ignored. A pointer load in the same cycle as an event wins, and that event is not recorded.
- R8: A read that targets the same entry an event writes in the same cycle returns the previous contents. The new contents are visible to a read presented on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_enable | input | 1 | Global recording enable |
| evt_valid | input | 1 | Event strobe, one per control-flow change |
| evt_src | input | ADDR_W | Address the flow left |
| evt_dst | input | ADDR_W | Address the flow went to |
| tos_wr_en | input | 1 | Load the pointer register |
| tos_wr_data | input | ADDR_W | Value to load; only the low log2(DEPTH) bits are used |
| rd_addr | input | log2(DEPTH)+2 | Register read address: bank in the top two bits, entry index below |
| rd_data | output | ADDR_W | Read result, registered, one cycle after rd_addr |

## Verification
The bench builds the block with `DEPTH=4` and the default 64-bit address width. With only four entries, the wrap from entry 3 back to entry 0 and the overwrite of the oldest pair take just a handful of events. The 64-bit width leaves 62 pointer-register bits above the 2-bit pointer, which makes zero-filling those bits and ignoring loaded data in them observable. The bench covers the read of the bank-3 hole, a pointer load that collides with an event, and a read that collides with a write to the same entry.

// File: rtl/btr_pkg.sv
// Shared types for the branch trace ring buffer.
// Assumes the read address carries the bank selector in its top two bits.
package btr_pkg;
    typedef enum logic [1:0] {
        BANK_SRC  = 2'd0,
        BANK_DST  = 2'd1,
        BANK_TOS  = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;
endpackage

// File: rtl/btr_tos_ptr.sv
// Newest-entry pointer. It advances on each accepted event and can be loaded
// by software. A load beats an event in the same cycle.
// Assumes DEPTH is a power of two, so natural wrap gives modulo DEPTH.
module btr_tos_ptr #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_enable,
    input  logic             evt_valid,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    output logic [IDX_W-1:0] ptr,
    output logic             rec,
    output logic [IDX_W-1:0] rec_idx
);
    // Decide whether this cycle records an event, and where it goes.
    always_comb begin
        rec     = rec_enable && evt_valid && !load_en;
        rec_idx = ptr + IDX_W'(1);
    end

    // Pointer register: reset to the last entry, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= IDX_W'(DEPTH - 1);
        else if (load_en) ptr <= load_idx;
        else if (rec)     ptr <= rec_idx;
    end

    assert_reset_ptr_R1: assert property (@(posedge clk)
        !rst_n |=> ptr == IDX_W'(DEPTH - 1));
    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_enable && evt_valid && !load_en) |=> ptr == $past(ptr) + IDX_W'(1));
    assert_hold_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_enable && !load_en) |=> $stable(ptr));
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ptr == $past(load_idx));
endmodule

// File: rtl/btr_entry_bank.sv
// One bank of DEPTH address registers, with one write port.
// Assumes the write strobe and index come already qualified from the pointer unit.
module btr_entry_bank #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] mem [DEPTH]
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Entry register: clear on reset, take new data when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[e] <= '0;
            else if (we && widx == IDX_W'(e))    mem[e] <= wdata;
        end

        assert_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == IDX_W'(e)) |=> $stable(mem[e]));
    end
endmodule

// File: rtl/btr_read_port.sv
// Registered read mux over the two entry banks and the pointer register.
// Assumes the address is {bank, index}; bank 3 is a hole that reads zero.
module btr_read_port #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RA_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   rd_addr,
    input  logic [ADDR_W-1:0] src_mem [DEPTH],
    input  logic [ADDR_W-1:0] dst_mem [DEPTH],
    input  logic [IDX_W-1:0]  ptr,
    output logic [ADDR_W-1:0] rd_data
);
    import btr_pkg::*;

    bank_e             bank;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] rd_next;

    // Split the address and select the addressed register.
    always_comb begin
        bank    = bank_e'(rd_addr[RA_W-1 -: 2]);
        idx     = rd_addr[IDX_W-1:0];
        rd_next = '0;
        case (bank)
            BANK_SRC: rd_next = src_mem[idx];
            BANK_DST: rd_next = dst_mem[idx];
            BANK_TOS: rd_next[IDX_W-1:0] = ptr;
            default:  rd_next = '0;
        endcase
    end

    // Output register: one cycle of read latency; reads before writes land.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    assert_tos_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[RA_W-1 -: 2] == 2'd2) |=> rd_data[ADDR_W-1:IDX_W] == '0);
    assert_hole_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[RA_W-1 -: 2] == 2'd3) |=> rd_data == '0);
endmodule

// File: rtl/branch_trace_ring.sv
// Branch trace ring buffer top. It records source/destination pairs of
// qualified control-flow events and serves register-style reads.
// Assumes events arrive already qualified, at most one per cycle, and that
// DEPTH is 4, 8 or 16.
module branch_trace_ring #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RA_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_enable,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_src,
    input  logic [ADDR_W-1:0] evt_dst,
    input  logic              tos_wr_en,
    input  logic [ADDR_W-1:0] tos_wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [ADDR_W-1:0] rd_data
);
    logic [IDX_W-1:0]  ptr;
    logic              rec;
    logic [IDX_W-1:0]  rec_idx;
    logic [ADDR_W-1:0] src_mem [DEPTH];
    logic [ADDR_W-1:0] dst_mem [DEPTH];

    btr_tos_ptr #(.DEPTH(DEPTH)) ptr_i (
        .clk(clk), .rst_n(rst_n), .rec_enable(rec_enable), .evt_valid(evt_valid),
        .load_en(tos_wr_en), .load_idx(tos_wr_data[IDX_W-1:0]),
        .ptr(ptr), .rec(rec), .rec_idx(rec_idx)
    );

    btr_entry_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) src_bank_i (
        .clk(clk), .rst_n(rst_n), .we(rec), .widx(rec_idx),
        .wdata(evt_src), .mem(src_mem)
    );

    btr_entry_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dst_bank_i (
        .clk(clk), .rst_n(rst_n), .we(rec), .widx(rec_idx),
        .wdata(evt_dst), .mem(dst_mem)
    );

    btr_read_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .src_mem(src_mem),
        .dst_mem(dst_mem), .ptr(ptr), .rd_data(rd_data)
    );

    assert_record_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_enable && evt_valid && !tos_wr_en) |=> src_mem[ptr] == $past(evt_src)
            && dst_mem[ptr] == $past(evt_dst));
    assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_enable |=> $stable(src_mem[0]) && $stable(dst_mem[0]));
endmodule

// File: tb/branch_trace_ring_tb_top.sv
// Directed bench: one task per scenario, DEPTH=4, 64-bit addresses.
module branch_trace_ring_tb_top;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 64;
    localparam int IDX_W  = 2;
    localparam int RA_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rec_enable = 1'b0;
    logic              evt_valid = 1'b0;
    logic [ADDR_W-1:0] evt_src = '0;
    logic [ADDR_W-1:0] evt_dst = '0;
    logic              tos_wr_en = 1'b0;
    logic [ADDR_W-1:0] tos_wr_data = '0;
    logic [RA_W-1:0]   rd_addr = '0;
    logic [ADDR_W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [ADDR_W-1:0] m_src [DEPTH];
    logic [ADDR_W-1:0] m_dst [DEPTH];
    int m_ptr;

    branch_trace_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (.*);

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present an address at a falling edge, sample one clock later.
    task automatic rd(input logic [1:0] bank, input int idx,
                      output logic [ADDR_W-1:0] val);
        rd_addr = {bank, IDX_W'(idx)};
        @(posedge clk); @(negedge clk);
        val = rd_data;
    endtask

    task automatic event_pulse(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d);
        evt_valid = 1'b1; evt_src = s; evt_dst = d;
        @(posedge clk); @(negedge clk);
        evt_valid = 1'b0;
        if (rec_enable) begin
            m_ptr = (m_ptr + 1) % DEPTH;
            m_src[m_ptr] = s; m_dst[m_ptr] = d;
        end
    endtask

    task automatic check_all(input string req);
        logic [ADDR_W-1:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'd0, i, v); check(req, v, m_src[i]);
            rd(2'd1, i, v); check(req, v, m_dst[i]);
        end
        rd(2'd2, 0, v); check(req, v, ADDR_W'(m_ptr));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin m_src[i] = '0; m_dst[i] = '0; end
        m_ptr = DEPTH - 1;
        check_all("R1 reset state");
    endtask

    task automatic t_first_events();
        rec_enable = 1'b1;
        event_pulse(64'hA000_0000_0000_1000, 64'h5000_0000_0000_2000);
        event_pulse(64'hA000_0000_0000_1004, 64'h5000_0000_0000_3000);
        check_all("R2 record order");
    endtask

    task automatic t_wrap();
        for (int n = 0; n < 5; n++)
            event_pulse(64'hC0DE_0000_0000_0000 | 64'(n), 64'hFACE_0000_0000_0000 | 64'(n));
        check_all("R3 wrap and overwrite");
    endtask

    task automatic t_disable();
        rec_enable = 1'b0;
        event_pulse(64'hDEAD_DEAD_DEAD_DEAD, 64'hBEEF_BEEF_BEEF_BEEF);
        event_pulse(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222);
        check_all("R4 disabled strobes ignored");
        rec_enable = 1'b1;
    endtask

    task automatic t_read_map();
        logic [ADDR_W-1:0] v;
        rd(2'd3, 1, v); check("R5 bank 3 reads zero", v, '0);
        rd(2'd1, 2, v); check("R5 dst bank index 2", v, m_dst[2]);
    endtask

    task automatic t_tos_load();
        logic [ADDR_W-1:0] v;
        tos_wr_en = 1'b1; tos_wr_data = 64'hFFFF_FFFF_FFFF_FFF1;
        evt_valid = 1'b1; evt_src = 64'h7777; evt_dst = 64'h8888;
        @(posedge clk); @(negedge clk);
        tos_wr_en = 1'b0; evt_valid = 1'b0;
        m_ptr = 1;
        rd(2'd2, 0, v);
        check("R7 load low bits only", v, 64'd1);
        check("R6 upper pointer bits zero", v >> IDX_W, '0);
        check_all("R7 colliding event dropped");
        event_pulse(64'h9999_0000, 64'hAAAA_0000);
        check_all("R7 advance from loaded pointer");
    endtask

    task automatic t_collision();
        logic [ADDR_W-1:0] old_src;
        int tgt;
        tgt = (m_ptr + 1) % DEPTH;
        old_src = m_src[tgt];
        rd_addr = {2'd0, IDX_W'(tgt)};
        evt_valid = 1'b1; evt_src = 64'h0123_4567_89AB_CDEF; evt_dst = 64'h42;
        @(posedge clk); @(negedge clk);
        evt_valid = 1'b0;
        check("R8 same-cycle read returns old", rd_data, old_src);
        @(posedge clk); @(negedge clk);
        check("R8 next-cycle read returns new", rd_data, 64'h0123_4567_89AB_CDEF);
        m_ptr = tgt; m_src[tgt] = 64'h0123_4567_89AB_CDEF; m_dst[tgt] = 64'h42;
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_first_events();
                t_wrap();
                t_disable();
                t_read_map();
                t_tos_load();
                t_collision();
                t_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule